// File: doc/BRIEF.md
# Smart-Card Character Waiting-Time Watchdog

This block watches the I/O line of an ISO 7816 smart-card interface and reports when the card has stayed silent for too long. It runs from the system clock. A clock-enable input marks each card-clock cycle, and all timing is counted in those enabled cycles. Time is measured in whole character frames. One frame is twelve elementary time units (ETU): a start bit, eight data bits, parity and two stop bits. A frame therefore lasts twelve times the programmed clocks-per-ETU value.

Every falling edge on the I/O line restarts the measurement. Edges that are zero bits inside a character count too, so the real wait can run up to about one frame longer than the programmed value. When the required number of frames pass with no falling edge, the block emits a one-cycle expiry pulse. It also latches a sticky flag that software clears by writing a one. A waveform output goes high at a programmable point inside each frame and goes low again at the frame boundary.

Configuration uses a simple write port with four addresses:

| Address | Register | Reset value | Write effect |
|---|---|---|---|
| 0 | clocks per ETU | 372 | restarts both counters |
| 1 | waiting time in ETU | 9600 | restarts both counters |
| 2 | clear strobes | — | write-one-to-clear, does not restart |
| 3 | compare point for the waveform | 186 | restarts both counters |

At address 2, bit 0 clears the sticky flag and bit 1 forces the waveform low.

The control state machine has three states:
- RUN: frames are counted.
- FIRE: the expiry pulse is high and the counters are held at zero.
- RELOAD: the counters stay held for one more cycle before counting resumes.

Its transitions are:
- RUN to FIRE when the threshold is reached at a frame wrap.
- FIRE to RELOAD when no restart is present.
- FIRE to RUN when a restart is present.
- RELOAD to RUN unconditionally.
- RUN to RUN on a restart, which also clears the counters.

Top module: `scwt_watchdog`

## Requirements
- R1: After reset the clocks-per-ETU value is 372, the waiting time is 9600 ETU and the compare point is 186. The expiry pulse, the sticky flag and the waveform are all low, and counting starts from zero.
- R2: The frame counter counts enabled cycles from 0 to 12 × clocks-per-ETU − 1 and then wraps to zero. A clocks-per-ETU value of zero is treated as one.
- R3: The expiry threshold is the waiting time divided by 12, rounded down. A result of zero is treated as one. The first expiry pulse is seen threshold × frame-length enabled cycles after the clock edge that restarted counting.
- R4: The expiry pulse is one cycle wide. The state machine then goes FIRE, RELOAD, RUN. With no edge on the line, the next pulse follows threshold × frame-length + 2 cycles after the previous one.
- R5: The I/O line passes through a two-flop synchroniser. A falling edge restarts counting at the third clock edge after the line goes low. Rising edges have no effect.
- R6: Every falling edge restarts the measurement, including a second falling edge within one character.
- R7: Edges are detected and counting advances only on cycles with the enable high. A low pulse on the line that starts and ends while the enable is low is ignored.
- R8: A write to address 0, 1 or 3 updates the value and clears both counters at the same clock edge. The next expiry is then a full threshold × frame-length later.
- R9: The waveform goes high the cycle after the frame counter equals the compare point. It goes low on a frame wrap, on a restart, or on a write to address 2 with bit 1 set. When a set and a clear meet in the same cycle, the clear wins.
- R10: The sticky flag is set by the expiry pulse and cleared by a write to address 2 with bit 0 set. When a set and a clear meet in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Card-clock enable, one pulse per card clock |
| io_line | input | 1 | Card I/O line, asynchronous, idles high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| expire | output | 1 | One-cycle waiting-time expiry pulse |
| expire_sticky | output | 1 | Latched expiry flag |
| wave_out | output | 1 | Frame waveform output |

## Verification
The bench measures the exact cycle of each expiry after a write or a line edge.

| Corner case | What a faulty design would show |
|---|---|
| Zero threshold, truncated threshold | An off-by-one threshold, or a missing clamp, shifts expiry by a whole frame or never fires. |
| Gap between back-to-back pulses | A pulse longer than one cycle, or a skipped RELOAD state, changes the gap. |
| Second falling edge inside a character; line rising mid-wait | Any edge mis-handling moves the expiry time away from the last falling edge. |
| Line pulse while the enable is low | Edge detection on disabled cycles restarts the count and delays the expiry. |
| Sticky clear landing on the expiry cycle | Letting the clear win loses the event. |
| Waveform rise, frame-boundary fall and software clear | A wrong compare or clear priority moves or drops the waveform edges by one cycle. |

// File: rtl/scwt_pkg.sv
package scwt_pkg;
    localparam int unsigned FRAME_ETU = 12;

    typedef enum logic [1:0] {
        S_RUN    = 2'd0,
        S_FIRE   = 2'd1,
        S_RELOAD = 2'd2
    } scwt_state_t;

    localparam logic [1:0] A_ETU  = 2'd0;
    localparam logic [1:0] A_WAIT = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_CMPA = 2'd3;
endpackage

// File: rtl/scwt_edge.sv
module scwt_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic io_line,
    output logic fall
);
    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              line_s;

    generate
        if (SYNC_N == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= io_line;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_N-2:0], io_line};
            end
        end
    endgenerate

    assign line_s = sync_q[SYNC_N-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  prev_q <= 1'b1;
        else if (ce) prev_q <= line_s;
    end

    assign fall = ce & prev_q & ~line_s;

    // R6: a detected fall is never repeated on the next cycle
    p_single_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/scwt_regs.sv
module scwt_regs #(
    parameter int CFG_W    = 16,
    parameter int ETU_RST  = 372,
    parameter int WAIT_RST = 9600,
    parameter int CMPA_RST = 186
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] etu_clks,
    output logic [CFG_W-1:0] wait_etu,
    output logic [CFG_W-1:0] cmp_pt,
    output logic             cfg_wr,
    output logic             sticky_clr,
    output logic             wave_clr
);
    import scwt_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            etu_clks <= CFG_W'(ETU_RST);
            wait_etu <= CFG_W'(WAIT_RST);
            cmp_pt   <= CFG_W'(CMPA_RST);
        end else if (wr_en) begin
            unique case (wr_addr)
                A_ETU:   etu_clks <= wr_data;
                A_WAIT:  wait_etu <= wr_data;
                A_CMPA:  cmp_pt   <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_wr     = wr_en && (wr_addr != A_CTRL);
        sticky_clr = wr_en && (wr_addr == A_CTRL) && wr_data[0];
        wave_clr   = wr_en && (wr_addr == A_CTRL) && wr_data[1];
    end
endmodule

// File: rtl/scwt_frame_ctr.sv
module scwt_frame_ctr #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             restart,
    input  logic             hold,
    input  logic [CNT_W-1:0] last,
    input  logic [CNT_W-1:0] cmp_pt,
    input  logic             wave_clr,
    output logic             wrap,
    output logic             wave
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == last);
    assign wrap    = ce & ~restart & ~hold & at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (restart || hold)  cnt_q <= '0;
        else if (ce)               cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    wave <= 1'b0;
        else if (wrap || restart || wave_clr)          wave <= 1'b0;
        else if (ce && !hold && (cnt_q == cmp_pt))     wave <= 1'b1;
    end

    // R2: counter never passes the frame end
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (cnt_q <= last));
    // R8: restart leaves the counter at zero
    p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
    // R9: a frame wrap drops the waveform
    p_wrap_clears_wave_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !wave);
endmodule

// File: rtl/scwt_ctrl.sv
module scwt_ctrl #(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             wrap,
    input  logic [CFG_W-1:0] thr,
    input  logic             sticky_clr,
    output logic             hold,
    output logic             expire,
    output logic             sticky
);
    import scwt_pkg::*;

    scwt_state_t      state_q, state_d;
    logic [CFG_W-1:0] evt_q;
    logic [CFG_W-1:0] evt_inc;
    logic             hit;

    assign evt_inc = evt_q + CFG_W'(1);
    assign hit     = wrap && (evt_inc >= thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:    if (!restart && hit) state_d = S_FIRE;
            S_FIRE:   state_d = restart ? S_RUN : S_RELOAD;
            S_RELOAD: state_d = S_RUN;
            default:  state_d = S_RUN;
        endcase
    end

    always_comb begin
        expire = (state_q == S_FIRE);
        hold   = (state_q != S_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            evt_q <= '0;
        else if (restart || state_q != S_RUN)  evt_q <= '0;
        else if (wrap)                         evt_q <= hit ? '0 : evt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          sticky <= 1'b0;
        else if (expire)     sticky <= 1'b1;
        else if (sticky_clr) sticky <= 1'b0;
    end

    // R3: frame events stay below the threshold while running
    p_evt_below_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |-> (evt_q < thr));
    // R4: expiry is a single-cycle pulse
    p_expire_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
    // R10: expiry always lands in the sticky flag
    p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> sticky);
endmodule

// File: rtl/scwt_watchdog.sv
module scwt_watchdog #(
    parameter int CFG_W    = 16,
    parameter int SYNC_N   = 2,
    parameter int ETU_RST  = 372,
    parameter int WAIT_RST = 9600,
    parameter int CMPA_RST = 186
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             io_line,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    output logic             expire,
    output logic             expire_sticky,
    output logic             wave_out
);
    import scwt_pkg::*;

    localparam int CNT_W = CFG_W + 4;

    logic [CFG_W-1:0] etu_clks, wait_etu, cmp_pt;
    logic             cfg_wr, sticky_clr, wave_clr;
    logic             fall, restart, hold, wrap;
    logic [CFG_W-1:0] etu_eff, thr_raw, thr_eff;
    logic [CNT_W-1:0] frame_last;

    scwt_regs #(
        .CFG_W(CFG_W), .ETU_RST(ETU_RST), .WAIT_RST(WAIT_RST), .CMPA_RST(CMPA_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .etu_clks(etu_clks), .wait_etu(wait_etu), .cmp_pt(cmp_pt),
        .cfg_wr(cfg_wr), .sticky_clr(sticky_clr), .wave_clr(wave_clr)
    );

    always_comb begin
        etu_eff    = (etu_clks == '0) ? CFG_W'(1) : etu_clks;
        thr_raw    = wait_etu / CFG_W'(FRAME_ETU);
        thr_eff    = (thr_raw == '0) ? CFG_W'(1) : thr_raw;
        frame_last = CNT_W'(etu_eff) * CNT_W'(FRAME_ETU) - CNT_W'(1);
    end

    scwt_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk(clk), .rst_n(rst_n), .ce(ce), .io_line(io_line), .fall(fall)
    );

    assign restart = fall | cfg_wr;

    scwt_frame_ctr #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .ce(ce), .restart(restart), .hold(hold),
        .last(frame_last), .cmp_pt(CNT_W'(cmp_pt)), .wave_clr(wave_clr),
        .wrap(wrap), .wave(wave_out)
    );

    scwt_ctrl #(.CFG_W(CFG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .restart(restart), .wrap(wrap), .thr(thr_eff),
        .sticky_clr(sticky_clr), .hold(hold), .expire(expire), .sticky(expire_sticky)
    );
endmodule

// File: tb/scwt_watchdog_test.sv
module scwt_watchdog_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b1;
    logic        io_line = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        expire, expire_sticky, wave_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int seen = 0;

    scwt_watchdog uut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .io_line(io_line),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .expire(expire), .expire_sticky(expire_sticky), .wave_out(wave_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: edge, then settle to negedge; counts expiry pulses seen
    task automatic step(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (expire) seen++;
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_exp(input int limit, input int raise_at, output int n);
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == raise_at) io_line = 1'b1;
            if (expire) return;
            if (n >= limit) begin n = -1; return; end
        end
    endtask

    task automatic cfg(input int etu, input int wt);
        wr(2'd0, etu);
        wr(2'd1, wt);
    endtask

    task automatic t_reset();
        chk("R1 expire after reset", expire, 0);
        chk("R1 sticky after reset", expire_sticky, 0);
        chk("R1 wave after reset", wave_out, 0);
        seen = 0;
        for (int n = 1; n <= 4464; n++) begin
            step(1);
            if (n == 186)  chk("R1 wave low before default compare", wave_out, 0);
            if (n == 187)  chk("R1 wave high after default compare", wave_out, 1);
            if (n == 4464) chk("R1 wave low at default frame end", wave_out, 0);
        end
        chk("R1 no early expiry with default wait", seen, 0);
    endtask

    task automatic t_period();
        int n;
        cfg(3, 12); wait_exp(500, -1, n);
        chk("R2 frame of 36 cycles, one frame", n, 36);
        cfg(2, 24); wait_exp(500, -1, n);
        chk("R2 frame of 24 cycles, two frames", n, 48);
    endtask

    task automatic t_thr();
        int n;
        cfg(2, 11); wait_exp(500, -1, n);
        chk("R3 zero threshold treated as one", n, 24);
        cfg(2, 35); wait_exp(500, -1, n);
        chk("R3 threshold rounds down", n, 48);
    endtask

    task automatic t_repeat();
        int n;
        cfg(2, 12); wait_exp(500, -1, n);
        chk("R4 first expiry", n, 24);
        wait_exp(500, -1, n);
        chk("R4 one-cycle pulse and gap", n, 26);
        chk("R10 sticky set", expire_sticky, 1);
        wr(2'd2, 1);
        chk("R10 sticky cleared by write one", expire_sticky, 0);
        wait_exp(500, -1, n);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 set wins over clear", expire_sticky, 1);
        wr(2'd2, 1);
        chk("R10 sticky cleared again", expire_sticky, 0);
    endtask

    task automatic t_edge();
        int n;
        cfg(2, 24); step(10);
        io_line = 1'b0;
        wait_exp(500, 6, n);
        chk("R5 falling edge restart, rising ignored", n, 51);
    endtask

    task automatic t_retrig();
        int n;
        cfg(2, 24); seen = 0; step(10);
        io_line = 1'b0; step(4);
        io_line = 1'b1; step(4);
        io_line = 1'b0;
        chk("R6 no expiry during character", seen, 0);
        wait_exp(500, 5, n);
        chk("R6 second edge in character restarts", n, 51);
    endtask

    task automatic t_ce();
        int n;
        cfg(2, 24); seen = 0;
        ce = 1'b0; step(2);
        io_line = 1'b0; step(3);
        io_line = 1'b1; step(5);
        ce = 1'b1;
        chk("R7 no expiry while disabled", seen, 0);
        wait_exp(500, -1, n);
        chk("R7 pulse during disabled cycles ignored", n, 48);
    endtask

    task automatic t_cfgwr();
        int n;
        cfg(2, 24); step(30);
        wr(2'd1, 24); wait_exp(500, -1, n);
        chk("R8 wait write restarts counting", n, 48);
        step(30);
        wr(2'd3, 100); wait_exp(500, -1, n);
        chk("R8 compare write restarts counting", n, 48);
    endtask

    task automatic t_wave();
        cfg(2, 240);
        wr(2'd3, 5);
        for (int n = 1; n <= 30; n++) begin
            step(1);
            if (n == 5)  chk("R9 wave low at compare cycle", wave_out, 0);
            if (n == 6)  chk("R9 wave high after compare", wave_out, 1);
            if (n == 23) chk("R9 wave high before wrap", wave_out, 1);
            if (n == 24) chk("R9 wave low at wrap", wave_out, 0);
            if (n == 30) chk("R9 wave high next frame", wave_out, 1);
        end
        wr(2'd2, 2);
        chk("R9 soft clear forces wave low", wave_out, 0);
        wr(2'd3, 23);
        step(24);
        chk("R9 clear wins when compare hits at wrap", wave_out, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_period();
        t_thr();
        t_repeat();
        t_edge();
        t_retrig();
        t_ce();
        t_cfgwr();
        t_wave();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc > WATCHDOG);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule